// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block sits on the host side of a linear photodiode array of `PIX` pixels. The array has a clock input, a one-shot start input and one or two analog outputs. The block derives the sensor clock from the system clock through a programmable divider. It places the start pulse between falling edges of the sensor clock, so the pulse has a full clock phase of setup and of hold. It then counts the rising edges of a readout frame. A serial frame has `PIX+1` edges: one edge per pixel, then one terminating edge. A parallel frame has `PIX/2+1` edges, because both halves of the array shift out together on two outputs.

After each rising edge that presents a pixel, the block waits a programmable number of system clocks so that the analog output can settle. It then pulses an ADC sample request together with the pixel index. In parallel mode a second request follows on the next system clock, for the pixel in the upper half. While `run` is held, frames repeat. Start edges are spaced by the programmed integration time, counted in sensor clock edges. A request shorter than the frame is raised to the frame length, so a new start never lands before the first legal edge after the terminating one.

Top module: `lsa_readout_seq`

## Requirements
- R1: `sen_clk` is low after reset. Each of its high and low phases lasts max(`cfg_half`,1) system clocks.
- R2: A serial frame (`cfg_par`=0) starts on the rising edge at which `sen_si` is high, which is edge 1. It ends on edge 129 for `PIX`=128. Rising edges 1..128 each produce one sample request, with `smp_idx` = edge-1 and `smp_ch`=0.
- R3: `sen_si` changes only while `sen_clk` is low. It rises at the falling edge before the start edge and falls at the next falling edge, so it is high for exactly one rising edge.
- R4: `smp_req` goes high max(`cfg_dly`,1) system clocks after `sen_clk` rises on a pixel edge, and lasts one system clock per request.
- R5: A parallel frame (`cfg_par`=1) ends on edge `PIX/2+1` (65). Edges 1..64 each give two requests on consecutive cycles. The first has `smp_ch`=0 and `smp_idx`=edge-1. The second has `smp_ch`=1 and `smp_idx`=edge-1+64.
- R6: While `run` is held, consecutive start edges are max(`cfg_int`, frame length) rising edges apart. The frame length is 129 in serial mode and 65 in parallel mode.
- R7: `busy` goes high in the cycle `sen_clk` rises on the start edge. It stays high until the terminating edge, where it drops.
- R8: `frame_done` is a single-cycle pulse in the cycle `sen_clk` rises on the terminating edge.
- R9: After reset, and with `run` low once a frame has completed, no start pulse, request or frame is produced. After reset `sen_si`, `smp_req`, `frame_done` and `busy` are low.
- R10: `cfg_par`, `cfg_int` and the frame length are captured at the start edge. Changing `cfg_par` during a frame does not alter that frame's length or its requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep starting frames while high |
| cfg_par | input | 1 | 0 = serial single output, 1 = two halves in parallel |
| cfg_half | input | DIV_W | Sensor clock phase length in system clocks (0 acts as 1) |
| cfg_int | input | INT_W | Requested start-to-start spacing in sensor clock edges |
| cfg_dly | input | DLY_W | Settling delay from sensor clock rise to sample request (0 acts as 1) |
| sen_clk | output | 1 | Clock to the sensor |
| sen_si | output | 1 | Start pulse to the sensor |
| smp_req | output | 1 | ADC sample request strobe |
| smp_idx | output | IDX_W | Pixel index of the current request |
| smp_ch | output | 1 | Output channel of the current request (1 = upper half in parallel mode) |
| frame_done | output | 1 | Pulse on the terminating edge of a frame |
| busy | output | 1 | High from the start edge to the terminating edge |

## Verification
A wrong edge count shows at the ports as soon as the frame ends. `frame_done` and the fall of `busy` arrive on an edge other than 129 or 65, and the count of requests in that frame is wrong. A wrong latched spacing appears at the next start pulse as a start-to-start distance that differs from max(`cfg_int`, frame length). A corrupted delay counter or index register shows up on the very next pixel edge, as a request that is displaced in time or carries the wrong index or channel.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  // raise a zero setting to the smallest usable value
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // rising edges from start edge to terminating edge inclusive
  function automatic int unsigned frame_edges(input logic par, input int unsigned pix);
    return par ? (pix / 2 + 1) : (pix + 1);
  endfunction

  // pixel periods that carry data in one frame
  function automatic int unsigned data_edges(input logic par, input int unsigned pix);
    return par ? (pix / 2) : pix;
  endfunction

  // start-to-start spacing, clamped up to the frame length
  function automatic int unsigned spacing(input int unsigned req, input int unsigned fl);
    return (req < fl) ? fl : req;
  endfunction
endpackage

// File: rtl/lsa_clkdiv.sv
module lsa_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_half,
  output logic             sen_clk,
  output logic             rise_ev,
  output logic             fall_ev
);
  import lsa_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_eff;
  logic             tick;

  assign half_eff = DIV_W'(at_least_one(32'(cfg_half)));
  assign tick     = (cnt >= half_eff - DIV_W'(1));
  assign rise_ev  = tick & ~sen_clk;
  assign fall_ev  = tick & sen_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sen_clk <= 1'b0;
    end else if (tick) begin
      cnt     <= '0;
      sen_clk <= ~sen_clk;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/lsa_frame_ctl.sv
module lsa_frame_ctl #(
  parameter int PIX   = 128,
  parameter int INT_W = 24,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_par,
  input  logic [INT_W-1:0] cfg_int,
  input  logic             rise_ev,
  input  logic             fall_ev,
  output logic             sen_si,
  output logic             busy,
  output logic             frame_done,
  output logic             pix_ev,
  output logic [IDX_W-1:0] pix_idx,
  output logic             pix_par
);
  import lsa_pkg::*;

  logic [INT_W-1:0] pos;
  logic [INT_W-1:0] per_l;
  logic [INT_W-1:0] fl_l;
  logic             par_l;
  logic [INT_W-1:0] fl_now;
  logic [INT_W-1:0] per_req;
  logic [INT_W-1:0] next_pos;
  logic [INT_W-1:0] np_eff;
  logic             restart_ok;

  assign fl_now     = INT_W'(frame_edges(cfg_par, PIX));
  assign per_req    = INT_W'(spacing(32'(cfg_int), 32'(fl_now)));
  assign restart_ok = run && ((pos == '0) || (pos >= per_l));

  always_comb begin
    if (sen_si)                               next_pos = INT_W'(1);
    else if ((pos == '0) || (pos >= per_l))   next_pos = '0;
    else                                      next_pos = pos + INT_W'(1);
  end

  assign pix_par = sen_si ? cfg_par : par_l;
  assign np_eff  = INT_W'(data_edges(pix_par, PIX));
  assign pix_ev  = rise_ev && (next_pos != '0) && (next_pos <= np_eff);
  assign pix_idx = IDX_W'(next_pos - INT_W'(1));
  assign busy    = (pos != '0) && (pos < fl_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sen_si     <= 1'b0;
      pos        <= '0;
      per_l      <= INT_W'(PIX + 1);
      fl_l       <= INT_W'(PIX + 1);
      par_l      <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= rise_ev && !sen_si && (next_pos == fl_l);
      if (fall_ev) sen_si <= restart_ok;
      if (rise_ev) begin
        pos <= next_pos;
        if (sen_si) begin
          per_l <= per_req;
          fl_l  <= fl_now;
          par_l <= cfg_par;
        end
      end
    end
  end
endmodule

// File: rtl/lsa_strobe.sv
module lsa_strobe #(
  parameter int PIX   = 128,
  parameter int IDX_W = 7,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic             pix_ev,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic             pix_par,
  output logic             smp_req,
  output logic [IDX_W-1:0] smp_idx,
  output logic             smp_ch
);
  import lsa_pkg::*;

  logic [DLY_W-1:0] dcnt;
  logic             pend;
  logic             second;
  logic             hold_par;
  logic [IDX_W-1:0] hold_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt     <= '0;
      pend     <= 1'b0;
      second   <= 1'b0;
      hold_par <= 1'b0;
      hold_idx <= '0;
      smp_req  <= 1'b0;
      smp_idx  <= '0;
      smp_ch   <= 1'b0;
    end else begin
      smp_req <= 1'b0;
      if (second) begin
        smp_req <= 1'b1;
        smp_idx <= hold_idx + IDX_W'(PIX / 2);
        smp_ch  <= 1'b1;
        second  <= 1'b0;
      end
      if (pix_ev) begin
        dcnt     <= DLY_W'(at_least_one(32'(cfg_dly)));
        pend     <= 1'b1;
        hold_idx <= pix_idx;
        hold_par <= pix_par;
      end else if (pend) begin
        if (dcnt == DLY_W'(1)) begin
          smp_req <= 1'b1;
          smp_idx <= hold_idx;
          smp_ch  <= 1'b0;
          pend    <= 1'b0;
          second  <= hold_par;
        end else begin
          dcnt <= dcnt - DLY_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lsa_readout_seq.sv
module lsa_readout_seq #(
  parameter int PIX   = 128,
  parameter int DIV_W = 16,
  parameter int INT_W = 24,
  parameter int DLY_W = 8,
  localparam int IDX_W = $clog2(PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_par,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [INT_W-1:0] cfg_int,
  input  logic [DLY_W-1:0] cfg_dly,
  output logic             sen_clk,
  output logic             sen_si,
  output logic             smp_req,
  output logic [IDX_W-1:0] smp_idx,
  output logic             smp_ch,
  output logic             frame_done,
  output logic             busy
);
  logic             rise_ev;
  logic             fall_ev;
  logic             pix_ev;
  logic [IDX_W-1:0] pix_idx;
  logic             pix_par;

  lsa_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half),
    .sen_clk(sen_clk), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  lsa_frame_ctl #(.PIX(PIX), .INT_W(INT_W), .IDX_W(IDX_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_par(cfg_par), .cfg_int(cfg_int),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .sen_si(sen_si), .busy(busy),
    .frame_done(frame_done), .pix_ev(pix_ev), .pix_idx(pix_idx), .pix_par(pix_par)
  );

  lsa_strobe #(.PIX(PIX), .IDX_W(IDX_W), .DLY_W(DLY_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .cfg_dly(cfg_dly), .pix_ev(pix_ev),
    .pix_idx(pix_idx), .pix_par(pix_par),
    .smp_req(smp_req), .smp_idx(smp_idx), .smp_ch(smp_ch)
  );
endmodule

// File: rtl/lsa_readout_chk.sv
module lsa_readout_chk #(
  parameter int PIX   = 128,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sen_clk,
  input logic             sen_si,
  input logic             smp_req,
  input logic [IDX_W-1:0] smp_idx,
  input logic             smp_ch,
  input logic             frame_done,
  input logic             busy,
  input logic             rise_ev
);
  logic last_si_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_si_rise <= 1'b0;
    else if (rise_ev) last_si_rise <= sen_si;
  end

  // R3
  si_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sen_si) |-> !sen_clk);

  // R3
  si_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sen_si) |-> !sen_clk);

  // R3
  si_single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && sen_si) |-> !last_si_rise);

  // R7
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($rose(sen_clk) && sen_si));

  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!busy && $past(busy) && $rose(sen_clk)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R4
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> busy);

  // R5
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && smp_ch) |-> (int'(smp_idx) >= PIX / 2));
endmodule

bind lsa_readout_seq lsa_readout_chk #(.PIX(PIX), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sen_clk(sen_clk), .sen_si(sen_si),
  .smp_req(smp_req), .smp_idx(smp_idx), .smp_ch(smp_ch),
  .frame_done(frame_done), .busy(busy), .rise_ev(rise_ev)
);

// File: tb/lsa_readout_seq_test.sv
module lsa_readout_seq_test;
  localparam int PIX = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_par = 1'b0;
  logic [15:0] cfg_half = 16'd2;
  logic [23:0] cfg_int = 24'd0;
  logic [7:0]  cfg_dly = 8'd1;
  logic        sen_clk, sen_si, smp_req, smp_ch, frame_done, busy;
  logic [6:0]  smp_idx;

  always #2 clk = ~clk;

  lsa_readout_seq uut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_par(cfg_par), .cfg_half(cfg_half),
    .cfg_int(cfg_int), .cfg_dly(cfg_dly), .sen_clk(sen_clk), .sen_si(sen_si),
    .smp_req(smp_req), .smp_idx(smp_idx), .smp_ch(smp_ch),
    .frame_done(frame_done), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  // monitor state, cleared on request
  logic mon_clr = 1'b0;
  int cyc = 0, rise_cyc = 0, hi_len = 0;
  int starts = 0, edges_since = 0, last_dist = 0;
  int dones = 0, done_edge = 0, busy_bad = 0, busy_start_bad = 0;
  int setup_bad = 0, si_long = 0, nstb = 0;
  logic prev_clk = 1'b0, prev_si = 1'b0, prev_rise_si = 1'b0;
  int idx_log [256];
  int ch_log  [256];
  int dly_log [256];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      starts = 0; edges_since = 0; last_dist = 0; dones = 0; done_edge = 0;
      busy_bad = 0; busy_start_bad = 0; setup_bad = 0; si_long = 0; nstb = 0;
    end else begin
      if (sen_clk && !prev_clk) begin
        if (sen_si) begin
          if (starts > 0) last_dist = edges_since;
          starts = starts + 1;
          edges_since = 1;
          if (!prev_si) setup_bad = setup_bad + 1;
          if (!busy) busy_start_bad = busy_start_bad + 1;
        end else begin
          edges_since = edges_since + 1;
        end
        if (sen_si && prev_rise_si) si_long = si_long + 1;
        prev_rise_si = sen_si;
        rise_cyc = cyc;
      end
      if (!sen_clk && prev_clk) hi_len = cyc - rise_cyc;
      if (frame_done) begin
        dones = dones + 1;
        done_edge = edges_since;
        if (busy) busy_bad = busy_bad + 1;
      end
      if (smp_req && nstb < 256) begin
        idx_log[nstb] = int'(smp_idx);
        ch_log[nstb]  = int'(smp_ch);
        dly_log[nstb] = cyc - rise_cyc;
        nstb = nstb + 1;
      end
    end
    prev_clk = sen_clk;
    prev_si  = sen_si;
  end

  // watchdog
  initial begin
    repeat (180000) @(posedge clk);
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr <= 1'b1;
    @(posedge clk); mon_clr <= 1'b0;
    @(posedge clk);
  endtask

  task automatic wait_cond_busy();
    for (int i = 0; i < 5000 && !busy; i++) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // R9 reset state
  task automatic t_reset();
    rst_n = 1'b0;
    settle(3);
    @(negedge clk);
    chk(sen_clk == 1'b0, "R1 reset sen_clk", int'(sen_clk), 0);
    chk(sen_si == 1'b0, "R9 reset sen_si", int'(sen_si), 0);
    chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    chk(smp_req == 1'b0 && frame_done == 1'b0, "R9 reset strobes",
        int'(smp_req) + int'(frame_done), 0);
    rst_n = 1'b1;
  endtask

  // one frame with run pulsed; flip toggles cfg_par mid-frame (R10)
  task automatic t_single(input logic par, input int half, input int dly, input bit flip);
    int fl, np, bad_seq, bad_dly;
    cfg_par = par; cfg_half = 16'(half); cfg_dly = 8'(dly); cfg_int = 24'd0;
    clear_mon();
    run = 1'b1;
    wait_cond_busy();
    run = 1'b0;
    if (flip) begin settle(40); cfg_par = ~par; end
    for (int i = 0; i < 20000 && dones == 0; i++) @(negedge clk);
    settle(4 * half);
    cfg_par = par;
    fl = par ? PIX / 2 + 1 : PIX + 1;
    np = par ? PIX : PIX;
    chk(starts == 1, "R9 one start", starts, 1);
    chk(dones == 1, "R8 one frame_done", dones, 1);
    chk(done_edge == fl, par ? "R5 frame edges" : "R2 frame edges", done_edge, fl);
    if (flip) chk(done_edge == fl, "R10 length held", done_edge, fl);
    chk(nstb == np, par ? "R5 request count" : "R2 request count", nstb, np);
    bad_seq = 0; bad_dly = 0;
    for (int j = 0; j < nstb; j++) begin
      int e_idx, e_ch, e_dly;
      if (par) begin
        e_ch = j % 2; e_idx = j / 2 + e_ch * (PIX / 2); e_dly = dly + e_ch;
      end else begin
        e_ch = 0; e_idx = j; e_dly = dly;
      end
      if (idx_log[j] != e_idx || ch_log[j] != e_ch) bad_seq++;
      if (dly_log[j] != e_dly) bad_dly++;
    end
    chk(bad_seq == 0, par ? "R5 index/channel order" : "R2 index order", bad_seq, 0);
    chk(bad_dly == 0, "R4 settle delay", bad_dly, 0);
    chk(hi_len == half, "R1 phase length", hi_len, half);
    chk(setup_bad == 0 && si_long == 0, "R3 start pulse shape", setup_bad + si_long, 0);
    chk(busy_bad == 0 && busy_start_bad == 0, "R7 busy window",
        busy_bad + busy_start_bad, 0);
    chk(busy == 1'b0, "R7 busy low after frame", int'(busy), 0);
  endtask

  // continuous frames: start spacing (R6)
  task automatic t_spacing(input logic par, input int req, input int exp);
    cfg_par = par; cfg_half = 16'd2; cfg_dly = 8'd1; cfg_int = 24'(req);
    clear_mon();
    run = 1'b1;
    for (int i = 0; i < 40000 && starts < 3; i++) @(negedge clk);
    run = 1'b0;
    chk(last_dist == exp, "R6 start spacing", last_dist, exp);
    chk(si_long == 0, "R3 no double start", si_long, 0);
    settle(4 * (exp + 10));
  endtask

  // run low: nothing happens (R9)
  task automatic t_idle();
    clear_mon();
    settle(3000);
    chk(starts == 0 && nstb == 0 && dones == 0, "R9 idle with run low",
        starts + nstb + dones, 0);
  endtask

  initial begin
    t_reset();
    settle(5);
    t_idle();
    t_single(1'b0, 2, 1, 1'b1);
    t_single(1'b0, 4, 3, 1'b0);
    t_single(1'b1, 4, 2, 1'b0);
    t_spacing(1'b0, 10, 129);
    t_spacing(1'b0, 200, 200);
    t_spacing(1'b1, 0, 65);
    t_idle();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule